// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is the serial front end of a 16-bit port expander. It watches an I2C bus through an oversampling system clock and answers one 7-bit address: a fixed 4-bit prefix (`0100` by default) followed by three strap inputs. That lets up to eight copies share one bus. SCL and SDA enter as plain inputs. SDA leaves as an open-drain enable that pulls the line low. An SCL enable also exists, but it stays released because the target never stretches the clock.

After the address is acknowledged, the transfer direction is set by the R/W bit.

- **Write:** the first byte is a register pointer. Each later byte goes to the register bank through a one-cycle write strobe.
- **Read:** each byte is fetched from the bank through a one-cycle read strobe and shifted out MSB first.

The pointer steps inside a register pair by flipping its low bit after every data byte. A repeated START lets a master set the pointer and then read from it in one transaction. Both bus lines pass through a synchronizer and a three-sample majority filter before START, STOP and clock edges are decoded.

Top module: `i2c_strap_target`

## Requirements
- R1: While reset is held, and directly after it, SDA and SCL are released (`sda_oe`=0, `scl_oe`=0), and no write or read strobe fires.
- R2: A STOP (SDA rising while SCL is high) at any bit position returns the target to idle. It releases SDA, and a partly received byte produces no write strobe.
- R3: After a START (SDA falling while SCL high), the eight bits are taken MSB first. Bits 7..4 must equal `0100`, bits 3..1 must equal `strap[2:0]`, and bit 0 is R/W (1 = read). On a match the target holds SDA low for the ninth clock.
- R4: On a non-matching address the target never drives SDA and fires no strobe until the next START or STOP.
- R5: In a write, the first byte after the address loads the pointer from its low three bits. Every later byte raises `wr_stb` for one cycle, with `wr_data` equal to the byte and `reg_addr` equal to the pointer. Each received byte is acknowledged.
- R6: After each data byte written or loaded for reading, bit 0 of the pointer flips, so transfers alternate inside a pair (7 → 6 → 7).
- R7: In a read, the target raises `rd_stb` and sends `rd_data` for the pointer MSB first. It pulls SDA low for each 0 bit and releases it in the ninth clock.
- R8: A master ACK after a read byte starts the next byte from the pair partner. A master NACK makes the target release SDA until a START or STOP, so further clocks read all ones.
- R9: A repeated START restarts address reception and keeps the pointer. The pointer also survives a STOP, so a read-only transaction continues where the last one left it.
- R10: The target begins pulling SDA low only while SCL is low.
- R11: A pulse lasting one clock sample on SDA (while SCL is high) or on SCL (while it is low) is ignored. It causes no START, STOP or extra bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | SCL pull-down enable, held released |
| sda_oe | output | 1 | SDA pull-down enable (1 = drive low) |
| strap | input | 3 | Hard-wired low address bits |
| reg_addr | output | PTR_W | Current register pointer |
| wr_stb | output | 1 | One-cycle write strobe to the register bank |
| wr_data | output | 8 | Byte written with `wr_stb` |
| rd_stb | output | 1 | One-cycle fetch strobe; `rd_data` is taken in this cycle |
| rd_data | input | 8 | Register content at `reg_addr` |

## Verification
Address decoding is swept in two ways. All 128 seven-bit addresses are sent against one strap value. Then every prefix-correct address is sent against each of the eight strap values. Together these separate errors in the fixed prefix from errors in the strap comparison, and a silent-after-mismatch byte shows whether a rejected target stays off the bus.

A three-byte write is issued at each of the eight pointer values, exposing wrong pair stepping and a lost pointer load. A combined write-then-read is also issued at each pointer, with ACK, ACK, NACK and one extra byte, followed by a read-only transaction. These tell apart byte order inside a pair, halting after a NACK, and pointer retention across repeated START and STOP.

Two further patterns cover abort and noise. An abort with a STOP in the middle of a byte checks that nothing is written. A data byte carrying single-sample glitches on both lines shows whether the filter holds.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int unsigned BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_RACK,
    ST_SEND,
    ST_SACK,
    ST_HALT
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } byte_phase_e;

  // true when more than half of the first taps bits are ones
  function automatic logic vote_major(input logic [7:0] win, input int unsigned taps);
    int unsigned ones;
    ones = 0;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < taps && win[i]) ones++;
    end
    return (ones * 2) > taps;
  endfunction

  // address byte: prefix in [7:4], strap in [3:1], R/W in [0]
  function automatic logic addr_hit(input logic [7:0] rx, input logic [3:0] prefix,
                                    input logic [2:0] strap);
    return rx[7:1] == {prefix, strap};
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  import i2c_tgt_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote_major(8'(win_q), VOTE_TAPS);
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine #(
  parameter logic [3:0]  ADDR_PREFIX = 4'b0100,
  parameter int unsigned PTR_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_f,
  input  logic [2:0]       strap,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             wr_stb,
  output logic [7:0]       wr_data,
  output logic             rd_stb
);
  import i2c_tgt_pkg::*;

  localparam logic [3:0]       LAST_BIT = 4'(BYTE_BITS);
  localparam logic [PTR_W-1:0] PAIR_BIT = PTR_W'(1);

  tgt_state_e  st_q;
  byte_phase_e ph_q;
  logic [3:0]       cnt_q;
  logic [7:0]       rx_q;
  logic [7:0]       tx_q;
  logic [PTR_W-1:0] ptr_q;
  logic             rw_q;
  logic             mack_q;

  logic byte_done, hit, load_now;

  always_comb begin
    byte_done = (st_q == ST_RECV) && scl_fall && (cnt_q == LAST_BIT);
    hit       = addr_hit(rx_q, ADDR_PREFIX, strap);
    wr_stb    = byte_done && (ph_q == PH_DATA);
    load_now  = ((st_q == ST_RACK) && scl_fall && (ph_q == PH_ADDR) && rw_q) ||
                ((st_q == ST_SACK) && scl_fall && mack_q);
  end

  assign rd_stb   = load_now;
  assign wr_data  = rx_q;
  assign reg_addr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st_q   <= ST_RECV;
      ph_q   <= PH_ADDR;
      cnt_q  <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RECV: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            rx_q  <= {rx_q[6:0], sda_f};
            cnt_q <= cnt_q + 4'd1;
          end
          if (byte_done) begin
            unique case (ph_q)
              PH_ADDR: begin
                if (hit) begin
                  rw_q   <= rx_q[0];
                  sda_oe <= 1'b1;
                  st_q   <= ST_RACK;
                end else begin
                  st_q <= ST_HALT;
                end
              end
              PH_CMD: begin
                ptr_q  <= rx_q[PTR_W-1:0];
                sda_oe <= 1'b1;
                st_q   <= ST_RACK;
              end
              default: begin
                ptr_q  <= ptr_q ^ PAIR_BIT;
                sda_oe <= 1'b1;
                st_q   <= ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (load_now) begin
              tx_q   <= rd_data;
              ptr_q  <= ptr_q ^ PAIR_BIT;
              sda_oe <= ~rd_data[7];
              st_q   <= ST_SEND;
            end else begin
              sda_oe <= 1'b0;
              st_q   <= ST_RECV;
              ph_q   <= (ph_q == PH_ADDR) ? PH_CMD : PH_DATA;
            end
          end
        end
        ST_SEND: begin
          if (scl_rise) cnt_q <= cnt_q + 4'd1;
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe <= 1'b0;
              st_q   <= ST_SACK;
            end else begin
              tx_q   <= {tx_q[6:0], 1'b0};
              sda_oe <= ~tx_q[6];
            end
          end
        end
        ST_SACK: begin
          if (scl_rise) mack_q <= ~sda_f;
          if (scl_fall) begin
            cnt_q <= '0;
            if (load_now) begin
              tx_q   <= rd_data;
              ptr_q  <= ptr_q ^ PAIR_BIT;
              sda_oe <= ~rd_data[7];
              st_q   <= ST_SEND;
            end else begin
              st_q <= ST_HALT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
  parameter logic [3:0]  ADDR_PREFIX = 4'b0100,
  parameter int unsigned PTR_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VOTE_TAPS   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [2:0]       strap,
  output logic [PTR_W-1:0] reg_addr,
  output logic             wr_stb,
  output logic [7:0]       wr_data,
  output logic             rd_stb,
  input  logic [7:0]       rd_data
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_tgt_engine #(
    .ADDR_PREFIX(ADDR_PREFIX),
    .PTR_W      (PTR_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_f    (sda_f),
    .strap    (strap),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb)
  );

  assign scl_oe = 1'b0;
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
  parameter int unsigned PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [PTR_W-1:0] reg_addr
);
  localparam logic [PTR_W-1:0] FLIP = PTR_W'(1);

  assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$stable(sda_oe)) |-> !scl_f);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_restart_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

  assert_write_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !scl_f);

  assert_write_pair_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> reg_addr == ($past(reg_addr) ^ FLIP));

  assert_read_pair_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> reg_addr == ($past(reg_addr) ^ FLIP));
endmodule

bind i2c_strap_target i2c_strap_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .sda_oe   (sda_oe),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .reg_addr (reg_addr)
);

// File: tb/i2c_strap_target_test.sv
module i2c_strap_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic scl_oe, sda_oe, wr_stb, rd_stb;
  logic [2:0] reg_addr;
  logic [7:0] wr_data, rd_data;
  logic scl_bus, sda_bus;

  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2c_strap_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .strap(strap), .reg_addr(reg_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  // register bank seen through the strobes
  logic [7:0] bank [8];
  int wr_count = 0;
  assign rd_data = bank[reg_addr];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'h00;
    end else if (wr_stb) begin
      bank[reg_addr] <= wr_data;
      wr_count <= wr_count + 1;
    end
  end

  int vectors = 0, fails = 0, high_drive = 0;
  logic oe_prev = 1'b0;
  bit done = 0;
  logic [7:0] expb [8];

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_bus) high_drive++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda_low = !b; wclk(HALF);
    m_scl_low = 1'b0; wclk(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0; wclk(HALF);
    m_scl_low = 1'b0; wclk(HALF/2);
    b = sda_bus; wclk(HALF - HALF/2);
    m_scl_low = 1'b1;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wclk(HALF);
    m_scl_low = 1'b0; wclk(HALF);
    m_sda_low = 1'b1; wclk(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wclk(HALF);
    m_scl_low = 1'b0; wclk(HALF);
    m_sda_low = 1'b0; wclk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_in(v);
      b[i] = v;
    end
    bit_out(!give_ack);
  endtask

  // byte with a one-sample SDA dip in bit 7 and a one-sample SCL blip in bit 2
  task automatic send_noisy_byte(input logic [7:0] b, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 7) begin
        m_sda_low = !b[i]; wclk(HALF);
        m_scl_low = 1'b0; wclk(HALF/2);
        m_sda_low = 1'b1; wclk(1);
        m_sda_low = !b[i]; wclk(HALF - HALF/2 - 1);
        m_scl_low = 1'b1;
      end else if (i == 2) begin
        m_sda_low = !b[i]; wclk(HALF/2);
        m_scl_low = 1'b0; wclk(1);
        m_scl_low = 1'b1; wclk(HALF - HALF/2 - 1);
        m_scl_low = 1'b0; wclk(HALF);
        m_scl_low = 1'b1;
      end else begin
        bit_out(b[i]);
      end
    end
    bit_in(a);
    ack = !a;
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] sel, input bit rd);
    return {4'b0100, sel, rd};
  endfunction

  initial begin
    bit ack;
    logic [7:0] got;
    int wc;
    for (int i = 0; i < 8; i++) expb[i] = 8'h00;

    // R1: reset state
    wclk(3);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    check(scl_oe == 1'b0, "R1 scl_oe in reset", scl_oe, 0);
    check(!wr_stb && !rd_stb, "R1 strobes in reset", {wr_stb, rd_stb}, 0);
    rst_n = 1'b1;
    wclk(10);
    check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

    // R3/R4: full 7-bit address sweep against strap 101
    strap = 3'b101;
    for (int a = 0; a < 128; a++) begin
      bit hit;
      hit = (a == {4'b0100, 3'b101});
      wc = wr_count;
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      check(ack == hit, "R3 address acknowledge", ack, hit);
      if (!hit) begin
        send_byte(8'h00, ack);
        check(ack == 1'b0 && wr_count == wc, "R4 silent after mismatch", {ack, 8'(wr_count - wc)}, 0);
      end
      bus_stop();
    end

    // R3: strap sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int t = 0; t < 8; t++) begin
        bus_start();
        send_byte(addr_byte(3'(t), 1'b0), ack);
        check(ack == (s == t), "R3 strap compare", ack, (s == t));
        bus_stop();
      end
    end
    strap = 3'b011;

    // R5/R6: three-byte writes at every pointer
    for (int p = 0; p < 8; p++) begin
      logic [7:0] d0, d1, d2;
      bit a0, a1, a2, a3, a4;
      d0 = 8'(p * 29 + 3);
      d1 = ~d0;
      d2 = d0 ^ 8'h5A;
      wc = wr_count;
      bus_start();
      send_byte(addr_byte(3'b011, 1'b0), a0);
      send_byte(8'(p), a1);
      send_byte(d0, a2);
      send_byte(d1, a3);
      send_byte(d2, a4);
      bus_stop();
      expb[p] = d0; expb[p ^ 1] = d1; expb[p] = d2;
      check(a0 && a1 && a2 && a3 && a4, "R5 write acknowledges", {a0, a1, a2, a3, a4}, 5'b11111);
      check(wr_count - wc == 3, "R5 write strobe count", wr_count - wc, 3);
      check(bank[p] == expb[p], "R6 pair write first", bank[p], expb[p]);
      check(bank[p ^ 1] == expb[p ^ 1], "R6 pair write partner", bank[p ^ 1], expb[p ^ 1]);
    end

    // R7/R8/R9: combined write-pointer then read, then read-only continuation
    for (int p = 0; p < 8; p++) begin
      bit a0, a1, a2;
      bus_start();
      send_byte(addr_byte(3'b011, 1'b0), a0);
      send_byte(8'(p), a1);
      bus_start();
      send_byte(addr_byte(3'b011, 1'b1), a2);
      check(a0 && a1 && a2, "R9 repeated start acknowledges", {a0, a1, a2}, 3'b111);
      recv_byte(1'b1, got);
      check(got == expb[p], "R7 first read byte", got, expb[p]);
      recv_byte(1'b1, got);
      check(got == expb[p ^ 1], "R8 partner after master ack", got, expb[p ^ 1]);
      recv_byte(1'b0, got);
      check(got == expb[p], "R8 third byte", got, expb[p]);
      recv_byte(1'b0, got);
      check(got == 8'hFF, "R8 released after master nack", got, 8'hFF);
      bus_stop();
      bus_start();
      send_byte(addr_byte(3'b011, 1'b1), a0);
      recv_byte(1'b0, got);
      bus_stop();
      check(a0 && got == expb[p ^ 1], "R9 pointer kept across stop", got, expb[p ^ 1]);
    end

    // R2: STOP inside a data byte
    begin
      bit a0, a1;
      wc = wr_count;
      bus_start();
      send_byte(addr_byte(3'b011, 1'b0), a0);
      send_byte(8'h02, a1);
      bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
      bus_stop();
      wclk(5);
      check(wr_count == wc, "R2 partial byte not written", wr_count - wc, 0);
      check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
      bus_start();
      send_byte(addr_byte(3'b011, 1'b1), a0);
      recv_byte(1'b0, got);
      bus_stop();
      check(a0 && got == expb[2], "R2 register intact after abort", got, expb[2]);
    end

    // R11: glitches on both lines inside a data byte
    begin
      bit a0, a1, a2;
      bus_start();
      send_byte(addr_byte(3'b011, 1'b0), a0);
      send_byte(8'h04, a1);
      send_noisy_byte(8'hA5, a2);
      bus_stop();
      expb[4] = 8'hA5;
      check(a0 && a1 && a2, "R11 acknowledges with glitches", {a0, a1, a2}, 3'b111);
      check(bank[4] == 8'hA5, "R11 glitched byte value", bank[4], 8'hA5);
      check(bank[5] == expb[5], "R11 partner untouched", bank[5], expb[5]);
    end

    // R10: drive onset only with SCL low over the whole run
    check(high_drive == 0, "R10 drive started while SCL high", high_drive, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule